// File: doc/BRIEF.md
# Dispatch Group Admission Controller

This block sits between an in-order micro-op queue and the out-of-order back end. Each cycle the queue presents up to `W` of its oldest micro-ops on parallel lanes, lane 0 being the oldest. The controller decides combinationally how many of them form this cycle's dispatch group. It walks the lanes in order and stops at the first micro-op that cannot be accepted. A micro-op is accepted only when it fits in several independent downstream credit pools: completion-buffer entries, rename registers, scheduler slots, load-queue slots and store-queue slots.

The controller holds each pool as a credit counter. Admission spends credits and the return inputs refill them. It also keeps performance statistics. One counter per stall cause records the cycles in which a full group could not be formed because of that cause. A histogram records how many micro-ops each cycle dispatched. The queue pops exactly the lanes flagged on `in_ready`.

Top module: `dsp_admit_ctrl`

## Requirements
- R1: After a synchronous active-high reset all stall and histogram counters read zero, and every credit pool holds its full capacity.
- R2: Admission is strictly in order. `in_ready` is always a thermometer code starting at lane 0 and is a subset of `in_valid`. The first invalid lane ends the queue for that cycle. A blocked micro-op also blocks every younger lane.
- R3: The effective group width is `cfg_width` when it lies in 1..W, and W when `cfg_width` is 0 or greater than W. Reaching the width limit is never charged as a stall.
- R4: Every admitted micro-op takes one completion-buffer entry. A micro-op that finds none left is blocked with cause index 0.
- R5: A micro-op with `in_has_dst` set takes one rename register, and a shortage blocks it with cause index 1. Credits count cumulatively over the younger lanes of the same group. With parameter `PRF_REGS` = 0 the register pool is unlimited and never blocks.
- R6: Every admitted micro-op takes one scheduler slot. A micro-op that finds none left is blocked with cause index 2.
- R7: A micro-op with `in_is_load` set takes one load-queue slot (cause index 3). One with `in_is_store` set takes one store-queue slot (cause index 4).
- R8: A micro-op with `in_solo` set must travel alone. It is blocked with cause index 5 unless it is in the first position of the group, and once admitted it blocks every younger lane with cause index 5.
- R9: In a cycle where fewer micro-ops than the effective width are admitted and a valid micro-op was blocked, exactly one stall counter increments. That counter is the one for the first failing check of the oldest blocked micro-op, checked in the order index 0, 1, 2, 3, 4, 5. Counter k sits at `stall_cnt[k*CW +: CW]`. No stall is charged when the queue simply ran out.
- R10: Every cycle out of reset increments exactly one histogram bin, bin n at `hist_cnt[n*CW +: CW]`, where n is the number of micro-ops admitted that cycle.
- R11: Credits returned on the `ret_*` inputs in a cycle are usable for admission from the next cycle on, not in the cycle of return.
- R12: Stall and histogram counters change at the clock edge that ends the cycle they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | $clog2(W+1) | Requested group width, 0 selects W |
| in_valid | input | W | Lane holds a micro-op (lane 0 oldest) |
| in_has_dst | input | W | Micro-op writes a renamed register |
| in_is_load | input | W | Micro-op needs a load-queue slot |
| in_is_store | input | W | Micro-op needs a store-queue slot |
| in_solo | input | W | Micro-op must be dispatched alone |
| in_ready | output | W | Lane admitted this cycle (queue pops it) |
| ret_rob | input | RET_W | Completion-buffer entries returned |
| ret_reg | input | RET_W | Rename registers returned |
| ret_sch | input | RET_W | Scheduler slots returned |
| ret_lq | input | RET_W | Load-queue slots returned |
| ret_sq | input | RET_W | Store-queue slots returned |
| stall_cnt | output | 6*CW | Stall-cause counters, index k at k*CW |
| hist_cnt | output | (W+1)*CW | Dispatch-count histogram, bin n at n*CW |

## Verification
`in_ready` is a combinational function of the current lanes and of the credits held at the start of the cycle. The bench drives lanes on the falling edge and reads the admission a quarter period before the rising edge. Returned credits take effect one edge later, so each credit-return scenario shows the lane still blocked in the return cycle and accepted in the following one. Stall and histogram counters are due right after the rising edge that closes the cycle. They are compared against the bench's own tally a quarter period after that edge, before the next stimulus is applied.

// File: rtl/dsp_admit_pkg.sv
package dsp_admit_pkg;

    localparam int NCAUSE = 6;

    typedef enum logic [2:0] {
        CAUSE_ROB   = 3'd0,
        CAUSE_REG   = 3'd1,
        CAUSE_SCHED = 3'd2,
        CAUSE_LQ    = 3'd3,
        CAUSE_SQ    = 3'd4,
        CAUSE_GROUP = 3'd5,
        CAUSE_NONE  = 3'd7
    } cause_e;

    typedef struct packed {
        logic has_dst;
        logic is_load;
        logic is_store;
        logic solo;
    } uop_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsp_credit_pool.sv
module dsp_credit_pool #(
    parameter int CAP   = 8,
    parameter int AW    = 4,
    parameter int WW    = 3,
    parameter int RET_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WW-1:0]    take,
    input  logic [RET_W-1:0] ret,
    output logic [AW-1:0]    free
);

    localparam logic UNLIMITED = (CAP == 0);

    logic [AW-1:0] free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= AW'(CAP);
        end else begin
            free_q <= free_q + AW'(ret) - AW'(take);
        end
    end

    // an unlimited pool always reports every bit set, which exceeds W
    assign free = free_q | {AW{UNLIMITED}};

endmodule

// File: rtl/dsp_admit_lanes.sv
module dsp_admit_lanes
    import dsp_admit_pkg::*;
#(
    parameter int W  = 4,
    parameter int AW = 5,
    parameter int WW = 3
) (
    input  logic [WW-1:0] lim,
    input  logic [W-1:0]  valid,
    input  uop_t          uops [W],
    input  logic [AW-1:0] free_rob,
    input  logic [AW-1:0] free_reg,
    input  logic [AW-1:0] free_sch,
    input  logic [AW-1:0] free_lq,
    input  logic [AW-1:0] free_sq,
    output logic [W-1:0]  admit,
    output logic [WW-1:0] n_admit,
    output logic [WW-1:0] n_reg,
    output logic [WW-1:0] n_ld,
    output logic [WW-1:0] n_st,
    output cause_e        cause
);

    always_comb begin
        int     n;
        int     nr;
        int     nl;
        int     ns;
        logic   blocked;
        logic   solo_open;
        cause_e c;

        n         = 0;
        nr        = 0;
        nl        = 0;
        ns        = 0;
        blocked   = 1'b0;
        solo_open = 1'b0;
        admit     = '0;
        cause     = CAUSE_NONE;

        for (int i = 0; i < W; i++) begin
            c = CAUSE_NONE;
            if (!blocked) begin
                if (!valid[i] || n >= int'(lim)) begin
                    blocked = 1'b1;
                end else begin
                    if (n + 1 > int'(free_rob)) begin
                        c = CAUSE_ROB;
                    end else if (uops[i].has_dst && (nr + 1 > int'(free_reg))) begin
                        c = CAUSE_REG;
                    end else if (n + 1 > int'(free_sch)) begin
                        c = CAUSE_SCHED;
                    end else if (uops[i].is_load && (nl + 1 > int'(free_lq))) begin
                        c = CAUSE_LQ;
                    end else if (uops[i].is_store && (ns + 1 > int'(free_sq))) begin
                        c = CAUSE_SQ;
                    end else if (solo_open || (uops[i].solo && n != 0)) begin
                        c = CAUSE_GROUP;
                    end

                    if (c == CAUSE_NONE) begin
                        admit[i] = 1'b1;
                        n = n + 1;
                        if (uops[i].has_dst)  nr = nr + 1;
                        if (uops[i].is_load)  nl = nl + 1;
                        if (uops[i].is_store) ns = ns + 1;
                        if (uops[i].solo)     solo_open = 1'b1;
                    end else begin
                        blocked = 1'b1;
                        cause   = c;
                    end
                end
            end
        end

        n_admit = WW'(n);
        n_reg   = WW'(nr);
        n_ld    = WW'(nl);
        n_st    = WW'(ns);
    end

endmodule

// File: rtl/dsp_admit_stats.sv
module dsp_admit_stats
    import dsp_admit_pkg::*;
#(
    parameter int W  = 4,
    parameter int WW = 3,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cause_e               cause,
    input  logic [WW-1:0]        n_admit,
    output logic [NCAUSE*CW-1:0] stall_cnt,
    output logic [(W+1)*CW-1:0]  hist_cnt
);

    generate
        for (genvar g = 0; g < NCAUSE; g++) begin : g_stall
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (cause == cause_e'(g)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign stall_cnt[g*CW +: CW] = cnt_q;
        end

        for (genvar b = 0; b <= W; b++) begin : g_hist
            logic [CW-1:0] bin_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bin_q <= '0;
                end else if (n_admit == WW'(b)) begin
                    bin_q <= bin_q + 1'b1;
                end
            end
            assign hist_cnt[b*CW +: CW] = bin_q;
        end
    endgenerate

endmodule

// File: rtl/dsp_admit_ctrl.sv
module dsp_admit_ctrl
    import dsp_admit_pkg::*;
#(
    parameter int W           = 4,
    parameter int ROB_ENTRIES = 16,
    parameter int PRF_REGS    = 12,
    parameter int SCH_ENTRIES = 8,
    parameter int LQ_ENTRIES  = 4,
    parameter int SQ_ENTRIES  = 4,
    parameter int RET_W       = 5,
    parameter int CW          = 16,
    localparam int WW         = $clog2(W + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WW-1:0]         cfg_width,
    input  logic [W-1:0]          in_valid,
    input  logic [W-1:0]          in_has_dst,
    input  logic [W-1:0]          in_is_load,
    input  logic [W-1:0]          in_is_store,
    input  logic [W-1:0]          in_solo,
    output logic [W-1:0]          in_ready,
    input  logic [RET_W-1:0]      ret_rob,
    input  logic [RET_W-1:0]      ret_reg,
    input  logic [RET_W-1:0]      ret_sch,
    input  logic [RET_W-1:0]      ret_lq,
    input  logic [RET_W-1:0]      ret_sq,
    output logic [NCAUSE*CW-1:0]  stall_cnt,
    output logic [(W+1)*CW-1:0]   hist_cnt
);

    localparam int MAXCAP = max_int(max_int(max_int(ROB_ENTRIES, PRF_REGS),
                                            max_int(SCH_ENTRIES, LQ_ENTRIES)),
                                    SQ_ENTRIES);
    localparam int AW     = max_int($clog2(MAXCAP + 1), WW);

    uop_t          uops [W];
    logic [WW-1:0] lim;
    logic [AW-1:0] free_rob, free_reg, free_sch, free_lq, free_sq;
    logic [WW-1:0] n_admit, n_reg, n_ld, n_st;
    cause_e        cause;

    generate
        for (genvar g = 0; g < W; g++) begin : g_lane
            assign uops[g] = '{has_dst:  in_has_dst[g],
                               is_load:  in_is_load[g],
                               is_store: in_is_store[g],
                               solo:     in_solo[g]};
        end
    endgenerate

    assign lim = (cfg_width == '0 || int'(cfg_width) > W) ? WW'(W) : cfg_width;

    dsp_credit_pool #(.CAP(ROB_ENTRIES), .AW(AW), .WW(WW), .RET_W(RET_W)) i_pool_rob (
        .clk(clk), .rst(rst), .take(n_admit), .ret(ret_rob), .free(free_rob));

    dsp_credit_pool #(.CAP(PRF_REGS), .AW(AW), .WW(WW), .RET_W(RET_W)) i_pool_reg (
        .clk(clk), .rst(rst), .take(n_reg), .ret(ret_reg), .free(free_reg));

    dsp_credit_pool #(.CAP(SCH_ENTRIES), .AW(AW), .WW(WW), .RET_W(RET_W)) i_pool_sch (
        .clk(clk), .rst(rst), .take(n_admit), .ret(ret_sch), .free(free_sch));

    dsp_credit_pool #(.CAP(LQ_ENTRIES), .AW(AW), .WW(WW), .RET_W(RET_W)) i_pool_lq (
        .clk(clk), .rst(rst), .take(n_ld), .ret(ret_lq), .free(free_lq));

    dsp_credit_pool #(.CAP(SQ_ENTRIES), .AW(AW), .WW(WW), .RET_W(RET_W)) i_pool_sq (
        .clk(clk), .rst(rst), .take(n_st), .ret(ret_sq), .free(free_sq));

    dsp_admit_lanes #(.W(W), .AW(AW), .WW(WW)) i_lanes (
        .lim      (lim),
        .valid    (in_valid),
        .uops     (uops),
        .free_rob (free_rob),
        .free_reg (free_reg),
        .free_sch (free_sch),
        .free_lq  (free_lq),
        .free_sq  (free_sq),
        .admit    (in_ready),
        .n_admit  (n_admit),
        .n_reg    (n_reg),
        .n_ld     (n_ld),
        .n_st     (n_st),
        .cause    (cause)
    );

    dsp_admit_stats #(.W(W), .WW(WW), .CW(CW)) i_stats (
        .clk       (clk),
        .rst       (rst),
        .cause     (cause),
        .n_admit   (n_admit),
        .stall_cnt (stall_cnt),
        .hist_cnt  (hist_cnt)
    );

endmodule

// File: rtl/dsp_admit_chk.sv
module dsp_admit_chk #(
    parameter int W       = 4,
    parameter int WW      = 3,
    parameter int CW      = 16,
    parameter int AW      = 5,
    parameter int ROB_CAP = 16,
    parameter int SCH_CAP = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [W-1:0]        in_valid,
    input logic [W-1:0]        in_ready,
    input logic [WW-1:0]       lim,
    input logic [AW-1:0]       free_rob,
    input logic [AW-1:0]       free_sch,
    input logic [6*CW-1:0]     stall_cnt,
    input logic [(W+1)*CW-1:0] hist_cnt
);

    logic                primed;
    logic [6*CW-1:0]     prev_stall;
    logic [(W+1)*CW-1:0] prev_hist;
    int                  stall_chg;
    int                  hist_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
        prev_stall <= stall_cnt;
        prev_hist  <= hist_cnt;
    end

    always_comb begin
        stall_chg = 0;
        hist_chg  = 0;
        for (int k = 0; k < 6; k++) begin
            if (stall_cnt[k*CW +: CW] != prev_stall[k*CW +: CW]) stall_chg++;
        end
        for (int b = 0; b <= W; b++) begin
            if (hist_cnt[b*CW +: CW] != prev_hist[b*CW +: CW]) hist_chg++;
        end
    end

    // R2
    thermo_order_chk: assert property (@(posedge clk) disable iff (rst)
        ((in_ready & (in_ready + 1'b1)) == '0) && ((in_ready & ~in_valid) == '0));

    // R3
    width_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(in_ready) <= int'(lim));

    // R4
    rob_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (free_rob == '0) |-> (in_ready == '0));

    // R6
    credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (free_sch <= AW'(SCH_CAP)) && (free_rob <= AW'(ROB_CAP)));

    // R10
    hist_one_bin_chk: assert property (@(posedge clk) disable iff (rst)
        primed |-> (hist_chg == 1));

    // R9
    stall_single_chk: assert property (@(posedge clk) disable iff (rst)
        primed |-> (stall_chg <= 1));

    // R9
    stall_short_group_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && stall_chg == 1) |-> ($past($countones(in_ready)) < $past(int'(lim))));

endmodule

bind dsp_admit_ctrl dsp_admit_chk #(
    .W(W), .WW(WW), .CW(CW), .AW(AW), .ROB_CAP(ROB_ENTRIES), .SCH_CAP(SCH_ENTRIES)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .lim       (lim),
    .free_rob  (free_rob),
    .free_sch  (free_sch),
    .stall_cnt (stall_cnt),
    .hist_cnt  (hist_cnt)
);

// File: tb/test_dsp_admit_ctrl.sv
module test_dsp_admit_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int CW = 16;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0]        cfg_width = '0;
    logic [W-1:0]      in_valid = '0, in_has_dst = '0, in_is_load = '0, in_is_store = '0, in_solo = '0;
    logic [RW-1:0]     ret_rob = '0, ret_reg = '0, ret_sch = '0, ret_lq = '0, ret_sq = '0;
    logic [W-1:0]      in_ready, b_ready;
    logic [6*CW-1:0]   stall_cnt, b_stall;
    logic [5*CW-1:0]   hist_cnt, b_hist;

    dsp_admit_ctrl #(.W(W), .ROB_ENTRIES(16), .PRF_REGS(12), .SCH_ENTRIES(8),
                     .LQ_ENTRIES(4), .SQ_ENTRIES(4), .RET_W(RW), .CW(CW)) i_dsp_admit_ctrl (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .in_valid(in_valid),
        .in_has_dst(in_has_dst), .in_is_load(in_is_load), .in_is_store(in_is_store),
        .in_solo(in_solo), .in_ready(in_ready), .ret_rob(ret_rob), .ret_reg(ret_reg),
        .ret_sch(ret_sch), .ret_lq(ret_lq), .ret_sq(ret_sq),
        .stall_cnt(stall_cnt), .hist_cnt(hist_cnt));

    // second instance: unlimited rename registers, large pools, no returns
    dsp_admit_ctrl #(.W(W), .ROB_ENTRIES(128), .PRF_REGS(0), .SCH_ENTRIES(128),
                     .LQ_ENTRIES(128), .SQ_ENTRIES(128), .RET_W(RW), .CW(CW)) i_dsp_admit_ctrl_unl (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .in_valid(in_valid),
        .in_has_dst(in_has_dst), .in_is_load(in_is_load), .in_is_store(in_is_store),
        .in_solo(in_solo), .in_ready(b_ready), .ret_rob('0), .ret_reg('0),
        .ret_sch('0), .ret_lq('0), .ret_sq('0),
        .stall_cnt(b_stall), .hist_cnt(b_hist));

    int checks = 0;
    int errors = 0;
    int exp_stall [6];
    int exp_hist  [5];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_counters(input string req);
        for (int k = 0; k < 6; k++)
            chk(req, $sformatf("stall counter %0d", k), int'(stall_cnt[k*CW +: CW]), exp_stall[k]);
        for (int b = 0; b <= W; b++)
            chk(req, $sformatf("histogram bin %0d", b), int'(hist_cnt[b*CW +: CW]), exp_hist[b]);
    endtask

    // one cycle: drive at falling edge, check admission before rising edge,
    // check counters after it. cause: 0 rob,1 reg,2 sched,3 lq,4 sq,5 group,-1 none
    task automatic step(input string req, input logic [2:0] cw,
                        input logic [3:0] v, input logic [3:0] d, input logic [3:0] l,
                        input logic [3:0] s, input logic [3:0] so,
                        input int rr, input int rg, input int rs, input int rl, input int rq,
                        input logic [3:0] exp_rdy, input int exp_cause, input int exp_b);
        @(negedge clk);
        cfg_width = cw; in_valid = v; in_has_dst = d; in_is_load = l;
        in_is_store = s; in_solo = so;
        ret_rob = RW'(rr); ret_reg = RW'(rg); ret_sch = RW'(rs); ret_lq = RW'(rl); ret_sq = RW'(rq);
        #(CLK_PERIOD/4);
        chk(req, "in_ready", int'(in_ready), int'(exp_rdy));
        if (exp_b >= 0) chk(req, "unlimited in_ready", int'(b_ready), exp_b);
        @(posedge clk);
        exp_hist[$countones(exp_rdy)]++;
        if (exp_cause >= 0) exp_stall[exp_cause]++;
        #(CLK_PERIOD/4);
        check_counters(req);
    endtask

    task automatic t_reset;
        chk("R1", "in_ready idle", int'(in_ready), 0);
        check_counters("R1");
    endtask

    task automatic t_idle;
        step("R10", 3'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 0,0,0,0,0, 4'h0, -1, -1);
    endtask

    task automatic t_full_default;
        step("R3", 3'd0, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 0,0,0,0,0, 4'hF, -1, -1);
    endtask

    task automatic t_narrow;
        step("R3", 3'd2, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 0,0,0,0,0, 4'h3, -1, -1);
    endtask

    task automatic t_sched_full;
        step("R6", 3'd0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 0,0,0,0,0, 4'h3, 2, -1);
    endtask

    task automatic t_credit_return;
        step("R11", 3'd0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 0,0,8,0,0, 4'h0, 2, -1);
        step("R11", 3'd0, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 0,0,0,0,0, 4'hF, -1, -1);
    endtask

    task automatic t_inorder_lq;
        step("R2", 3'd0, 4'h7, 4'h0, 4'h1, 4'h0, 4'h0, 0,0,0,0,0, 4'h0, 3, -1);
    endtask

    task automatic t_priority;
        step("R4", 3'd0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 0,0,0,0,0, 4'hF, -1, -1);
        step("R9", 3'd0, 4'h1, 4'h0, 4'h1, 4'h0, 4'h0, 0,0,0,0,0, 4'h0, 0, -1);
        step("R12", 3'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16,4,8,4,0, 4'h0, -1, -1);
    endtask

    task automatic t_reg_cumulative;
        step("R5", 3'd0, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4,0,4,0,0, 4'hF, -1, -1);
        step("R5", 3'd0, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4,0,4,0,0, 4'hF, -1, -1);
        step("R5", 3'd0, 4'h7, 4'h7, 4'h0, 4'h0, 4'h0, 3,0,3,0,0, 4'h7, -1, -1);
        step("R5", 3'd0, 4'hF, 4'h3, 4'h0, 4'h0, 4'h0, 0,0,0,0,0, 4'h1, 1, 15);
    endtask

    task automatic t_store_clamp;
        step("R3", 3'd7, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0, 0,0,0,0,0, 4'hF, -1, -1);
        step("R7", 3'd0, 4'h1, 4'h0, 4'h0, 4'h1, 4'h0, 0,0,0,0,0, 4'h0, 4, -1);
    endtask

    task automatic t_solo;
        step("R8", 3'd0, 4'h7, 4'h0, 4'h0, 4'h0, 4'h2, 0,0,0,0,0, 4'h1, 5, -1);
        step("R8", 3'd0, 4'h3, 4'h0, 4'h0, 4'h0, 4'h1, 0,0,0,0,0, 4'h1, 5, -1);
        step("R8", 3'd0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 0,0,0,0,0, 4'h1, -1, -1);
    endtask

    task automatic t_unlimited_end;
        chk("R5", "unlimited register stall counter", int'(b_stall[1*CW +: CW]), 0);
    endtask

    initial begin
        for (int k = 0; k < 6; k++) exp_stall[k] = 0;
        for (int b = 0; b < 5; b++) exp_hist[b] = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst = 1'b0;
        #1;
        t_reset();
        t_idle();
        t_full_default();
        t_narrow();
        t_sched_full();
        t_credit_return();
        t_inorder_lq();
        t_priority();
        t_reg_cumulative();
        t_store_clamp();
        t_solo();
        t_unlimited_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule